// File: doc/BRIEF.md
# Synchronization Writeback/Invalidate Sequencer

This block sits beside a small write-back L1 data array and performs the software-coherence work a core needs at a synchronization point. A command names the event: lock acquire, lock release or barrier. The sequencer then walks every line of the array in ascending index order. Each line tracks its dirty state per word. A line with at least one dirty word is sent to memory as a single write that carries the line address, the full line data and a word mask holding only the dirty words. Partial writes from different cores to different words of the same line therefore never overwrite each other.

A release only cleans lines and leaves them valid. An acquire or a barrier also drops every valid bit, so that later reads fetch fresh data. For both of these events the block sends a one-cycle invalidate pulse to an attached page-mapping table when it finishes. The array's fill and probe ports give the surrounding cache a way to install lines and to read line state. Installs are refused while a walk is running.

Top module: `sync_flush_seq`

## Requirements
- R1: After reset, busy, done, map_inv and mem_valid are low, and every line reads back invalid with all dirty bits clear.
- R2: A release (cmd_type 2'b01) writes back every line that holds dirty words. Every line that was valid is still valid afterwards and has no dirty words. map_inv stays low.
- R3: A lock acquire (cmd_type 2'b00) writes back the dirty lines and leaves every line invalid and clean. map_inv is high in the same cycle as done.
- R4: A barrier (cmd_type 2'b10) writes back the dirty lines and leaves every line invalid and clean. map_inv is high in the same cycle as done.
- R5: Each memory write has mem_addr = {tag, line index} (the index in the low IDX_W bits). mem_wmask is the line's per-word dirty mask, with bit w standing for word w. Word w of mem_data sits at bits [w*DATA_W +: DATA_W]. A line with no dirty words produces no write.
- R6: Within one command, writes are issued in ascending line-index order.
- R7: When no line needs a writeback, done rises LINES+1 clock edges after the edge that accepts the start, counting the accepting edge. Each line therefore takes one cycle.
- R8: While mem_valid is high and mem_ready is low, mem_valid stays high and mem_addr, mem_data and mem_wmask hold their values. The walk does not move past the line until the handshake completes.
- R9: done is high for exactly one cycle per command, and busy is low in that cycle.
- R10: A start, or a fill, presented while busy is high has no effect. No second walk follows, and the filled line is not installed.
- R11: cmd_type 2'b11 is not a command. Presenting it with cmd_start does not raise busy, produces no writes and leaves all line state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start request, sampled while idle |
| cmd_type | input | 2 | 00 acquire, 01 release, 10 barrier, 11 none |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |
| map_inv | output | 1 | One-cycle page-map invalidate pulse (acquire, barrier) |
| fill_en | input | 1 | Install a line (ignored while busy) |
| fill_idx | input | IDX_W | Line index to install |
| fill_tag | input | TAG_W | Tag of the installed line |
| fill_data | input | WORDS*DATA_W | Line data, word w at [w*DATA_W +: DATA_W] |
| fill_dirty | input | WORDS | Per-word dirty bits of the installed line |
| probe_idx | input | IDX_W | Line index to read back |
| probe_valid | output | 1 | Valid bit of the probed line, one cycle later |
| probe_dirty | output | WORDS | Dirty bits of the probed line, one cycle later |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | TAG_W+IDX_W | Line address {tag, index} |
| mem_data | output | WORDS*DATA_W | Line data |
| mem_wmask | output | WORDS | Per-word write mask |

## Verification
On every cycle, the assertions check several rules. A pending write must hold steady until it is accepted. done must be a single-cycle pulse with busy already low. map_inv may appear only alongside done. No write may be pending while the block is idle. Every write must carry a non-zero mask. A real command must raise busy, and the non-command code must not. Other properties need a picture of the whole array, and only the bench scenarios can show them. These are the exact set of lines written and their ascending order, the address, mask and data of each write, the valid and dirty state left behind by each event type, the one-line-per-cycle pace, and the refusal of starts and fills that arrive mid-walk.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  // Synchronization event codes presented on cmd_type.
  typedef enum logic [1:0] {
    CMD_ACQ = 2'b00,
    CMD_REL = 2'b01,
    CMD_BAR = 2'b10,
    CMD_NOP = 2'b11
  } sync_cmd_e;

  // Walker states.
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_ISSUE,
    ST_WAIT
  } walk_st_e;

  // Events after which no line may stay valid.
  function automatic logic cmd_invalidates(sync_cmd_e c);
    return (c == CMD_ACQ) || (c == CMD_BAR);
  endfunction

endpackage

// File: rtl/sfs_line_store.sv
module sfs_line_store #(
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 8,
  parameter int IDX_W  = $clog2(LINES)   // derived, keep at default
) (
  input  logic                    clk,
  input  logic                    rst,
  // install port
  input  logic                    fill_we,
  input  logic [IDX_W-1:0]        fill_idx,
  input  logic [TAG_W-1:0]        fill_tag,
  input  logic [WORDS*DATA_W-1:0] fill_data,
  input  logic [WORDS-1:0]        fill_dirty,
  // walker read port
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [WORDS*DATA_W-1:0] rd_data_q,
  output logic [TAG_W-1:0]        rd_tag_q,
  output logic                    cur_valid,
  output logic [WORDS-1:0]        cur_dirty,
  // walker clear port
  input  logic                    clr_en,
  input  logic                    clr_valid,
  // probe port
  input  logic [IDX_W-1:0]        probe_idx,
  output logic                    probe_valid,
  output logic [WORDS-1:0]        probe_dirty
);

  localparam int LINE_W = WORDS * DATA_W;

  // Data and tag arrays: synchronous write, registered read.
  logic [LINE_W-1:0] data_mem [LINES];
  logic [TAG_W-1:0]  tag_mem  [LINES];

  always_ff @(posedge clk) begin
    if (fill_we) begin
      data_mem[fill_idx] <= fill_data;
      tag_mem[fill_idx]  <= fill_tag;
    end
    rd_data_q <= data_mem[rd_idx];
    rd_tag_q  <= tag_mem[rd_idx];
  end

  // Per-line state kept in flops so the walker can bulk clear it.
  logic [LINES-1:0] valid_q;
  logic [WORDS-1:0] dirty_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic hit_fill;
    logic hit_clr;
    assign hit_fill = fill_we && (fill_idx == IDX_W'(g));
    assign hit_clr  = clr_en  && (rd_idx   == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[g] <= 1'b0;
        dirty_q[g] <= '0;
      end else if (hit_fill) begin
        valid_q[g] <= 1'b1;
        dirty_q[g] <= fill_dirty;
      end else if (hit_clr) begin
        dirty_q[g] <= '0;
        if (clr_valid) begin
          valid_q[g] <= 1'b0;
        end
      end
    end
  end

  assign cur_valid = valid_q[rd_idx];
  assign cur_dirty = dirty_q[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      probe_valid <= 1'b0;
      probe_dirty <= '0;
    end else begin
      probe_valid <= valid_q[probe_idx];
      probe_dirty <= dirty_q[probe_idx];
    end
  end

endmodule

// File: rtl/sfs_walker.sv
module sfs_walker
  import sfs_pkg::*;
#(
  parameter int LINES = 16,
  parameter int WORDS = 4,
  parameter int IDX_W = $clog2(LINES)    // derived, keep at default
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_start,
  input  logic [1:0]       cmd_type,
  input  logic             cur_valid,
  input  logic [WORDS-1:0] cur_dirty,
  input  logic             wr_accepted,
  output logic [IDX_W-1:0] idx,
  output logic             issue,
  output logic             clr_en,
  output logic             clr_valid,
  output logic             busy,
  output logic             done,
  output logic             map_inv
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

  walk_st_e  st;
  sync_cmd_e cmd_in;
  logic      inv_q;
  logic      need_wb;
  logic      step;

  assign cmd_in  = sync_cmd_e'(cmd_type);
  assign need_wb = cur_valid && (|cur_dirty);

  // Leave the current line: clean line in SCAN, or accepted write in WAIT.
  assign step = ((st == ST_SCAN) && !need_wb) ||
                ((st == ST_WAIT) && wr_accepted);

  assign issue     = (st == ST_ISSUE);
  assign clr_en    = step;
  assign clr_valid = inv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      idx     <= '0;
      inv_q   <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      map_inv <= 1'b0;
    end else begin
      done    <= 1'b0;
      map_inv <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (cmd_start && (cmd_in != CMD_NOP)) begin
            st    <= ST_SCAN;
            idx   <= '0;
            inv_q <= cmd_invalidates(cmd_in);
            busy  <= 1'b1;
          end
        end
        ST_SCAN: begin
          if (need_wb) begin
            st <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          st <= ST_WAIT;
        end
        ST_WAIT: begin
          // stay until the memory accepts the write
        end
        default: st <= ST_IDLE;
      endcase

      if (step) begin
        if (idx == LAST_IDX) begin
          st      <= ST_IDLE;
          busy    <= 1'b0;
          done    <= 1'b1;
          map_inv <= inv_q;
        end else begin
          idx <= idx + 1'b1;
          st  <= ST_SCAN;
        end
      end
    end
  end

endmodule

// File: rtl/sfs_wb_port.sv
module sfs_wb_port #(
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [ADDR_W-1:0]       load_addr,
  input  logic [WORDS*DATA_W-1:0] load_data,
  input  logic [WORDS-1:0]        load_mask,
  input  logic                    mem_ready,
  output logic                    mem_valid,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [WORDS*DATA_W-1:0] mem_data,
  output logic [WORDS-1:0]        mem_wmask,
  output logic                    accepted
);

  assign accepted = mem_valid && mem_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
      mem_wmask <= '0;
    end else if (load) begin
      mem_valid <= 1'b1;
      mem_addr  <= load_addr;
      mem_data  <= load_data;
      mem_wmask <= load_mask;
    end else if (accepted) begin
      mem_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/sync_flush_seq.sv
module sync_flush_seq #(
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 8,
  parameter int IDX_W  = $clog2(LINES),          // derived, keep at default
  parameter int ADDR_W = TAG_W + $clog2(LINES)   // derived, keep at default
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cmd_start,
  input  logic [1:0]              cmd_type,
  output logic                    busy,
  output logic                    done,
  output logic                    map_inv,
  input  logic                    fill_en,
  input  logic [IDX_W-1:0]        fill_idx,
  input  logic [TAG_W-1:0]        fill_tag,
  input  logic [WORDS*DATA_W-1:0] fill_data,
  input  logic [WORDS-1:0]        fill_dirty,
  input  logic [IDX_W-1:0]        probe_idx,
  output logic                    probe_valid,
  output logic [WORDS-1:0]        probe_dirty,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [WORDS*DATA_W-1:0] mem_data,
  output logic [WORDS-1:0]        mem_wmask
);

  localparam int LINE_W = WORDS * DATA_W;

  logic [IDX_W-1:0]  walk_idx;
  logic [LINE_W-1:0] rd_data_q;
  logic [TAG_W-1:0]  rd_tag_q;
  logic              cur_valid;
  logic [WORDS-1:0]  cur_dirty;
  logic              clr_en;
  logic              clr_valid;
  logic              issue;
  logic              accepted;
  logic              fill_we;

  // Installs are refused during a walk.
  assign fill_we = fill_en && !busy;

  sfs_line_store #(
    .LINES (LINES),
    .WORDS (WORDS),
    .DATA_W(DATA_W),
    .TAG_W (TAG_W),
    .IDX_W (IDX_W)
  ) u_store (
    .clk        (clk),
    .rst        (rst),
    .fill_we    (fill_we),
    .fill_idx   (fill_idx),
    .fill_tag   (fill_tag),
    .fill_data  (fill_data),
    .fill_dirty (fill_dirty),
    .rd_idx     (walk_idx),
    .rd_data_q  (rd_data_q),
    .rd_tag_q   (rd_tag_q),
    .cur_valid  (cur_valid),
    .cur_dirty  (cur_dirty),
    .clr_en     (clr_en),
    .clr_valid  (clr_valid),
    .probe_idx  (probe_idx),
    .probe_valid(probe_valid),
    .probe_dirty(probe_dirty)
  );

  sfs_walker #(
    .LINES(LINES),
    .WORDS(WORDS),
    .IDX_W(IDX_W)
  ) u_walker (
    .clk        (clk),
    .rst        (rst),
    .cmd_start  (cmd_start),
    .cmd_type   (cmd_type),
    .cur_valid  (cur_valid),
    .cur_dirty  (cur_dirty),
    .wr_accepted(accepted),
    .idx        (walk_idx),
    .issue      (issue),
    .clr_en     (clr_en),
    .clr_valid  (clr_valid),
    .busy       (busy),
    .done       (done),
    .map_inv    (map_inv)
  );

  sfs_wb_port #(
    .WORDS (WORDS),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_wb (
    .clk      (clk),
    .rst      (rst),
    .load     (issue),
    .load_addr({rd_tag_q, walk_idx}),
    .load_data(rd_data_q),
    .load_mask(cur_dirty),
    .mem_ready(mem_ready),
    .mem_valid(mem_valid),
    .mem_addr (mem_addr),
    .mem_data (mem_data),
    .mem_wmask(mem_wmask),
    .accepted (accepted)
  );

endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cmd_start,
  input logic [1:0]              cmd_type,
  input logic                    busy,
  input logic                    done,
  input logic                    map_inv,
  input logic                    mem_valid,
  input logic                    mem_ready,
  input logic [ADDR_W-1:0]       mem_addr,
  input logic [WORDS*DATA_W-1:0] mem_data,
  input logic [WORDS-1:0]        mem_wmask
);

  // R8: a pending write holds until accepted
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_wmask)));

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: busy already low when done is seen
  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R3 / R4: the map invalidate only comes with the end of a walk
  p_mapinv_done_r3: assert property (@(posedge clk) disable iff (rst)
    map_inv |-> done);

  // R5: a write always carries at least one dirty word
  p_mask_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_wmask != '0));

  // R10: no write is pending while idle
  p_no_wr_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_valid);

  // R11: the non-command code does not start a walk
  p_nop_ignored_r11: assert property (@(posedge clk) disable iff (rst)
    (!busy && cmd_start && (cmd_type == 2'b11)) |=> !busy);

  // R2: a real command is accepted when idle
  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && !done && cmd_start && (cmd_type != 2'b11)) |=> busy);

endmodule

bind sync_flush_seq sfs_checker #(
  .WORDS (WORDS),
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd_start(cmd_start),
  .cmd_type (cmd_type),
  .busy     (busy),
  .done     (done),
  .map_inv  (map_inv),
  .mem_valid(mem_valid),
  .mem_ready(mem_ready),
  .mem_addr (mem_addr),
  .mem_data (mem_data),
  .mem_wmask(mem_wmask)
);

// File: tb/sync_flush_seq_bench.sv
`timescale 1ns/1ps
module sync_flush_seq_bench;

  localparam int LINES  = 16;
  localparam int WORDS  = 4;
  localparam int DATA_W = 32;
  localparam int TAG_W  = 8;
  localparam int IDX_W  = $clog2(LINES);
  localparam int ADDR_W = TAG_W + IDX_W;
  localparam int LINE_W = WORDS * DATA_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_start = 1'b0;
  logic [1:0]        cmd_type = 2'b01;
  logic              busy, done, map_inv;
  logic              fill_en = 1'b0;
  logic [IDX_W-1:0]  fill_idx = '0;
  logic [TAG_W-1:0]  fill_tag = '0;
  logic [LINE_W-1:0] fill_data = '0;
  logic [WORDS-1:0]  fill_dirty = '0;
  logic [IDX_W-1:0]  probe_idx = '0;
  logic              probe_valid;
  logic [WORDS-1:0]  probe_dirty;
  logic              mem_valid;
  logic              mem_ready = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic [LINE_W-1:0] mem_data;
  logic [WORDS-1:0]  mem_wmask;

  always #2.5 clk = ~clk;

  sync_flush_seq #(
    .LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W)
  ) u_sync_flush_seq (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_type(cmd_type),
    .busy(busy), .done(done), .map_inv(map_inv),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag),
    .fill_data(fill_data), .fill_dirty(fill_dirty),
    .probe_idx(probe_idx), .probe_valid(probe_valid), .probe_dirty(probe_dirty),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_wmask(mem_wmask)
  );

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  finished = 0;

  // bench-side picture of the array
  bit               m_valid [LINES];
  logic [WORDS-1:0] m_dirty [LINES];
  logic [TAG_W-1:0] m_tag   [LINES];

  // memory-side log
  int                rdy_delay = 0;
  int                wcnt = 0;
  int                log_n = 0;
  int                hold_err = 0;
  logic [ADDR_W-1:0] log_addr [64];
  logic [WORDS-1:0]  log_mask [64];
  logic [LINE_W-1:0] log_data [64];
  logic [ADDR_W-1:0] first_addr;
  logic [LINE_W-1:0] first_data;
  logic [WORDS-1:0]  first_mask;

  function automatic logic [LINE_W-1:0] line_pattern(logic [TAG_W-1:0] t, int idx);
    logic [LINE_W-1:0] v;
    for (int w = 0; w < WORDS; w++) begin
      v[w*DATA_W +: DATA_W] = {t, 8'(idx), 8'(w), 8'h5A};
    end
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory responder and write logger
  always @(negedge clk) begin
    if (mem_ready) begin
      mem_ready = 1'b0;
      wcnt = 0;
    end else if (mem_valid) begin
      if (wcnt == 0) begin
        first_addr = mem_addr;
        first_data = mem_data;
        first_mask = mem_wmask;
      end
      if (wcnt >= rdy_delay) begin
        if (mem_addr != first_addr || mem_data != first_data || mem_wmask != first_mask)
          hold_err++;
        mem_ready = 1'b1;
        if (log_n < 64) begin
          log_addr[log_n] = mem_addr;
          log_mask[log_n] = mem_wmask;
          log_data[log_n] = mem_data;
        end
        log_n++;
      end else begin
        wcnt++;
      end
    end
  end

  task automatic fill_line(input int idx, input logic [TAG_W-1:0] t,
                           input logic [WORDS-1:0] d);
    @(negedge clk);
    fill_en    = 1'b1;
    fill_idx   = IDX_W'(idx);
    fill_tag   = t;
    fill_data  = line_pattern(t, idx);
    fill_dirty = d;
    @(negedge clk);
    fill_en = 1'b0;
    m_valid[idx] = 1'b1;
    m_dirty[idx] = d;
    m_tag[idx]   = t;
  endtask

  task automatic probe_all(input string req);
    for (int i = 0; i < LINES; i++) begin
      @(negedge clk);
      probe_idx = IDX_W'(i);
      @(negedge clk);
      check(probe_valid == m_valid[i], req, $sformatf("line %0d valid", i),
            probe_valid, m_valid[i]);
      check(probe_dirty == m_dirty[i], req, $sformatf("line %0d dirty", i),
            probe_dirty, m_dirty[i]);
    end
  endtask

  // Runs one command, checks the write stream and the end pulse.
  task automatic run_cmd(input logic [1:0] t, input int dly, input int disturb,
                         input string req, output int edges, output bit saw_map);
    int exp_idx [LINES];
    int exp_n = 0;
    int n = 0;
    for (int i = 0; i < LINES; i++) begin
      if (m_valid[i] && (m_dirty[i] != '0)) begin
        exp_idx[exp_n] = i;
        exp_n++;
      end
    end
    log_n = 0;
    hold_err = 0;
    rdy_delay = dly;
    saw_map = 1'b0;
    @(negedge clk);
    cmd_start = 1'b1;
    cmd_type  = t;
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      cmd_start = 1'b0;
      fill_en   = 1'b0;
      if (done) begin
        saw_map = map_inv;
        break;
      end
      if (n == disturb) begin
        // R10: mid-walk start and install
        cmd_start  = 1'b1;
        cmd_type   = 2'b01;
        fill_en    = 1'b1;
        fill_idx   = '0;
        fill_tag   = 8'hEE;
        fill_data  = line_pattern(8'hEE, 0);
        fill_dirty = 4'b1111;
      end
      if (n > 4000) begin
        check(1'b0, req, "done never rose", 0, 1);
        break;
      end
    end
    edges = n;
    @(negedge clk);
    check(done == 1'b0, "R9", "done width", done, 0);
    check(busy == 1'b0, "R9", "busy after done", busy, 0);
    check(log_n == exp_n, "R5", {req, " write count"}, log_n, exp_n);
    check(hold_err == 0, "R8", "write held until ready", hold_err, 0);
    for (int k = 0; k < exp_n && k < log_n && k < 64; k++) begin
      int i = exp_idx[k];
      logic [ADDR_W-1:0] ea = {m_tag[i], IDX_W'(i)};
      check(log_addr[k] == ea, "R6", $sformatf("write %0d addr", k), log_addr[k], ea);
      check(log_mask[k] == m_dirty[i], "R5", $sformatf("write %0d mask", k),
            log_mask[k], m_dirty[i]);
      for (int w = 0; w < WORDS; w++) begin
        if (m_dirty[i][w]) begin
          logic [DATA_W-1:0] ew = line_pattern(m_tag[i], i)[w*DATA_W +: DATA_W];
          check(log_data[k][w*DATA_W +: DATA_W] == ew, "R5",
                $sformatf("write %0d word %0d", k, w),
                log_data[k][w*DATA_W +: DATA_W], ew);
        end
      end
    end
    for (int i = 0; i < LINES; i++) begin
      m_dirty[i] = '0;
      if (t != 2'b01) m_valid[i] = 1'b0;
    end
    probe_all(req);
  endtask

  task automatic t_reset();
    check(busy == 1'b0, "R1", "busy", busy, 0);
    check(done == 1'b0, "R1", "done", done, 0);
    check(map_inv == 1'b0, "R1", "map_inv", map_inv, 0);
    check(mem_valid == 1'b0, "R1", "mem_valid", mem_valid, 0);
    probe_all("R1");
  endtask

  task automatic t_release();
    int e; bit mp;
    fill_line(3, 8'h11, 4'b0101);
    fill_line(5, 8'h22, 4'b0000);
    fill_line(7, 8'h33, 4'b1111);
    fill_line(15, 8'h44, 4'b1000);
    run_cmd(2'b01, 0, 0, "R2", e, mp);
    check(mp == 1'b0, "R2", "map_inv on release", mp, 0);
  endtask

  task automatic t_acquire();
    int e; bit mp;
    fill_line(0, 8'h55, 4'b0010);
    fill_line(9, 8'h66, 4'b0110);
    run_cmd(2'b00, 1, 0, "R3", e, mp);
    check(mp == 1'b1, "R3", "map_inv on acquire", mp, 1);
  endtask

  task automatic t_barrier();
    int e; bit mp;
    fill_line(2, 8'h77, 4'b1111);
    fill_line(4, 8'h88, 4'b0001);
    fill_line(12, 8'h99, 4'b1100);
    fill_line(13, 8'hAA, 4'b0000);
    run_cmd(2'b10, 3, 0, "R4", e, mp);
    check(mp == 1'b1, "R4", "map_inv on barrier", mp, 1);
  endtask

  task automatic t_clean_pace();
    int e; bit mp;
    fill_line(6, 8'hBB, 4'b0000);
    run_cmd(2'b01, 0, 0, "R7", e, mp);
    check(e == LINES + 1, "R7", "edges to done, clean array", e, LINES + 1);
  endtask

  task automatic t_busy_ignore();
    int e; bit mp;
    int extra = 0;
    fill_line(1, 8'hCC, 4'b0011);
    fill_line(10, 8'hDD, 4'b0101);
    run_cmd(2'b00, 0, 3, "R10", e, mp);
    for (int c = 0; c < 24; c++) begin
      @(negedge clk);
      if (busy || mem_valid) extra++;
    end
    check(extra == 0, "R10", "second walk after ignored start", extra, 0);
    check(log_n == 2, "R10", "writes incl. ignored start", log_n, 2);
    probe_all("R10");
  endtask

  task automatic t_nop();
    int seen = 0;
    int e; bit mp;
    fill_line(8, 8'h3C, 4'b1001);
    log_n = 0;
    @(negedge clk);
    cmd_start = 1'b1;
    cmd_type  = 2'b11;
    @(negedge clk);
    cmd_start = 1'b0;
    for (int c = 0; c < 20; c++) begin
      if (busy || done || mem_valid) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R11", "activity after code 11", seen, 0);
    check(log_n == 0, "R11", "writes after code 11", log_n, 0);
    probe_all("R11");
    run_cmd(2'b01, 0, 0, "R11", e, mp);
  endtask

  initial begin
    for (int i = 0; i < LINES; i++) begin
      m_valid[i] = 1'b0;
      m_dirty[i] = '0;
      m_tag[i]   = '0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_release();
    t_acquire();
    t_barrier();
    t_clean_pace();
    t_busy_ignore();
    t_nop();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule